// File: doc/BRIEF.md
# Tamper Security Supervisor

This block tracks the security condition of a battery-backed unit. It keeps two sticky condition flags. The invalid flag is set by a battery-domain reset. The violation flag is set when any enabled tamper source fires. With both flags clear the unit is valid. The tamper sensors, and the two counter-overflow detectors, reach the block as digital pulse inputs, one per source. A source fires the violation only if its bit in the source-enable register is set, and the block then also latches a detect flag for that source. While either condition flag is set, the block freezes its own seconds counter.

Software reaches the block through a single-cycle register port. Status bits are write-one-to-clear. The block enforces a strict recovery order: disable all sources, clear the detect flags, clear the violation flag, and clear the invalid flag last. The violation flag can only be cleared while the invalid flag is set. A system reset taken during a violation sets the invalid flag, which opens that path. Configuration locks come in two kinds. Soft locks are lost on a system reset. Hard locks, and the failure lock that makes a violation permanent, survive until a battery-domain reset. A level interrupt reports the violation flag when its enable is set.

Top module: `tmon_supervisor`

## Requirements
- R1: After a battery-domain reset, STATUS (address 0) reads with only the invalid flag (bit 17) set, SRC_EN (address 1), CTRL (address 2), IRQ_CTRL (address 3) and TIME (address 4) read 0, and `irq_o` is low.
- R2: A pulse on `tamper_i[k]` sets detect flag k (STATUS bit k) and the violation flag (STATUS bit 16) when SRC_EN bit k is 1. When that enable bit is 0 the pulse changes neither flag.
- R3: TIME increments by one per `tick_i` cycle while CTRL bit 3 (run) is 1 and both condition flags are clear. It holds while either flag is set. A write to TIME loads the value, except while the violation flag is set, when the write is ignored.
- R4: Writing 1 to STATUS bit k clears detect flag k, but not while `tamper_i[k]` is still high.
- R5: Writing 1 to STATUS bit 16 clears the violation flag only if all four of these hold: the invalid flag is set, all detect flags are already 0, SRC_EN is 0, and the failure lock is clear. If a detect flag is cleared in the same write, that flag does not count as cleared for this test.
- R6: Writing 1 to STATUS bit 17 clears the invalid flag only when the violation flag is already 0.
- R7: A cycle with `sys_rst_i` high does four things. It sets the invalid flag if the violation flag is set. It clears the soft lock (CTRL bit 0) and IRQ_CTRL bit 0. It leaves the detect flags, SRC_EN, the hard lock and the failure lock unchanged, and it ignores any register write in that cycle.
- R8: Writes to SRC_EN are ignored while the soft lock (CTRL bit 0) or the hard lock (CTRL bit 1) is set. The hard lock is cleared only by a battery-domain reset.
- R9: The soft lock, hard lock and failure lock (CTRL bits 0, 1, 2) can be set by writing 1 but never cleared by a write. CTRL bit 3 follows the written value.
- R10: While the failure lock (CTRL bit 2) is set, the violation flag cannot be cleared, even after the full recovery order.
- R11: `irq_o` is high exactly while the violation flag and IRQ_CTRL bit 0 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bat_rst_n | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_rst_i | input | 1 | System reset, synchronous, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| tamper_i | input | NSRC | Tamper source pulses, one per source |
| tick_i | input | 1 | One-second tick for the time counter |
| irq_o | output | 1 | Security-violation interrupt, level |

## Verification
Every state change in the block lands on the first rising edge after the write, pulse, tick or reset that causes it. The read port is combinational. In the default variant, `irq_o` is also combinational from the registers. So every result can be seen one clock after its stimulus. The bench drives each stimulus for exactly one cycle from a falling edge and reads back at the following falling edge, half a period after the update edge. It then walks every source through a failure, a system reset and the full recovery order, and computes each expected status word from the source index.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
   localparam int unsigned ADDR_W  = 3;
   localparam int unsigned SVF_BIT = 16;
   localparam int unsigned NVF_BIT = 17;

   localparam logic [ADDR_W-1:0] RA_STATUS = 3'd0;
   localparam logic [ADDR_W-1:0] RA_SRC_EN = 3'd1;
   localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd2;
   localparam logic [ADDR_W-1:0] RA_IRQ    = 3'd3;
   localparam logic [ADDR_W-1:0] RA_TIME   = 3'd4;

   // control register, soft lock in bit 0 .. run in bit 3
   typedef struct packed {
      logic run;
      logic fail_lock;
      logic hard_lock;
      logic soft_lock;
   } ctrl_t;
endpackage

// File: rtl/tmon_flags.sv
module tmon_flags #(
   parameter int unsigned NSRC = 10
) (
   input  logic            clk,
   input  logic            bat_rst_n,
   input  logic [NSRC-1:0] src_i,
   input  logic [NSRC-1:0] en_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] flags_o,
   output logic            event_o
);
   logic [NSRC-1:0] flag_q;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      always_ff @(posedge clk or negedge bat_rst_n) begin
         if (!bat_rst_n)                    flag_q[g] <= 1'b0;
         else if (src_i[g] && en_i[g])      flag_q[g] <= 1'b1;
         else if (clr_i[g] && !src_i[g])    flag_q[g] <= 1'b0;
      end

      AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!bat_rst_n)
         (src_i[g] && flag_q[g]) |=> flag_q[g]);  // R4
   end

   assign flags_o = flag_q;
   assign event_o = |(src_i & en_i);
endmodule

// File: rtl/tmon_state.sv
module tmon_state (
   input  logic clk,
   input  logic bat_rst_n,
   input  logic sys_rst_i,
   input  logic event_i,
   input  logic clr_svf_i,
   input  logic clr_nvf_i,
   input  logic flags_any_i,
   input  logic en_any_i,
   input  logic fail_lock_i,
   output logic svf_o,
   output logic nvf_o
);
   logic svf_q, nvf_q, svf_clear_ok;

   assign svf_clear_ok = clr_svf_i && nvf_q && !flags_any_i && !en_any_i && !fail_lock_i;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)         svf_q <= 1'b0;
      else if (event_i)       svf_q <= 1'b1;
      else if (svf_clear_ok)  svf_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)                 nvf_q <= 1'b1;
      else if (sys_rst_i && svf_q)    nvf_q <= 1'b1;
      else if (clr_nvf_i && !svf_q)   nvf_q <= 1'b0;
   end

   assign svf_o = svf_q;
   assign nvf_o = nvf_q;

   AST_SVF_NEEDS_NVF: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(svf_q) |-> $past(nvf_q));  // R5
   AST_NVF_CLEARS_LAST: assert property (@(posedge clk) disable iff (!bat_rst_n)
      $fell(nvf_q) |-> !$past(svf_q));  // R6
   AST_SYSRST_INVALID: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (sys_rst_i && svf_q) |=> nvf_q);  // R7
   AST_FAIL_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (fail_lock_i && svf_q) |=> svf_q);  // R10
endmodule

// File: rtl/tmon_cfg.sv
module tmon_cfg
   import tmon_pkg::*;
#(
   parameter int unsigned NSRC = 10
) (
   input  logic              clk,
   input  logic              bat_rst_n,
   input  logic              sys_rst_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [NSRC-1:0]   en_wdata_i,
   input  ctrl_t             ctrl_wdata_i,
   input  logic              irq_wdata_i,
   output logic [NSRC-1:0]   src_en_o,
   output ctrl_t             ctrl_o,
   output logic              irq_en_o
);
   logic [NSRC-1:0] en_q;
   ctrl_t           ctrl_q;
   logic            irq_en_q;
   logic            wr_ctrl, wr_en_reg, wr_irq, locked;

   assign wr_ctrl   = wr_en_i && (addr_i == RA_CTRL);
   assign wr_en_reg = wr_en_i && (addr_i == RA_SRC_EN);
   assign wr_irq    = wr_en_i && (addr_i == RA_IRQ);
   assign locked    = ctrl_q.soft_lock || ctrl_q.hard_lock;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)                  en_q <= '0;
      else if (wr_en_reg && !locked)   en_q <= en_wdata_i;
   end

   // soft lock and interrupt enable live in the system domain
   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n) begin
         ctrl_q.soft_lock <= 1'b0;
         irq_en_q         <= 1'b0;
      end else if (sys_rst_i) begin
         ctrl_q.soft_lock <= 1'b0;
         irq_en_q         <= 1'b0;
      end else begin
         if (wr_ctrl && ctrl_wdata_i.soft_lock) ctrl_q.soft_lock <= 1'b1;
         if (wr_irq)                            irq_en_q <= irq_wdata_i;
      end
   end

   // hard locks live in the battery domain only
   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n) begin
         ctrl_q.hard_lock <= 1'b0;
         ctrl_q.fail_lock <= 1'b0;
         ctrl_q.run       <= 1'b0;
      end else if (wr_ctrl) begin
         if (ctrl_wdata_i.hard_lock) ctrl_q.hard_lock <= 1'b1;
         if (ctrl_wdata_i.fail_lock) ctrl_q.fail_lock <= 1'b1;
         ctrl_q.run <= ctrl_wdata_i.run;
      end
   end

   assign src_en_o = en_q;
   assign ctrl_o   = ctrl_q;
   assign irq_en_o = irq_en_q;

   AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!bat_rst_n)
      locked |=> $stable(en_q));  // R8
   AST_HARD_LOCK_KEPT: assert property (@(posedge clk) disable iff (!bat_rst_n)
      !$fell(ctrl_q.hard_lock));  // R8
   AST_FAIL_LOCK_SET_ONLY: assert property (@(posedge clk) disable iff (!bat_rst_n)
      !$fell(ctrl_q.fail_lock));  // R9
endmodule

// File: rtl/tmon_timer.sv
module tmon_timer #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             bat_rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             frozen_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge bat_rst_n) begin
      if (!bat_rst_n)                          cnt_q <= '0;
      else if (load_i)                         cnt_q <= load_val_i;
      else if (tick_i && run_i && !frozen_i)   cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;

   AST_FROZEN_STOPS: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (frozen_i && !load_i) |=> $stable(cnt_q));  // R3
endmodule

// File: rtl/tmon_supervisor.sv
module tmon_supervisor
   import tmon_pkg::*;
#(
   parameter int unsigned NSRC           = 10,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned CNT_W          = 32,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              bat_rst_n,
   input  logic              sys_rst_i,
   input  logic              wr_en_i,
   input  logic [2:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NSRC-1:0]   tamper_i,
   input  logic              tick_i,
   output logic              irq_o
);
   localparam int unsigned STATUS_W = NVF_BIT + 1;

   if (NSRC < 1 || NSRC > SVF_BIT) begin : g_bad_nsrc
      $error("NSRC must lie between 1 and SVF_BIT");
   end
   if (DATA_W < STATUS_W) begin : g_bad_dw
      $error("DATA_W too narrow for the status word");
   end
   if (CNT_W > DATA_W || CNT_W < 1) begin : g_bad_cw
      $error("CNT_W must fit in DATA_W");
   end

   logic              wr_eff, wr_status, wr_time;
   logic [NSRC-1:0]   flags, src_en;
   logic              evt, svf, nvf, irq_en;
   ctrl_t             ctrl;
   logic [CNT_W-1:0]  count;

   assign wr_eff    = wr_en_i && !sys_rst_i;
   assign wr_status = wr_eff && (addr_i == RA_STATUS);
   assign wr_time   = wr_eff && (addr_i == RA_TIME) && !svf;

   tmon_cfg #(.NSRC(NSRC)) u_cfg (
      .clk         (clk),
      .bat_rst_n   (bat_rst_n),
      .sys_rst_i   (sys_rst_i),
      .wr_en_i     (wr_eff),
      .addr_i      (addr_i),
      .en_wdata_i  (wdata_i[NSRC-1:0]),
      .ctrl_wdata_i(ctrl_t'(wdata_i[3:0])),
      .irq_wdata_i (wdata_i[0]),
      .src_en_o    (src_en),
      .ctrl_o      (ctrl),
      .irq_en_o    (irq_en)
   );

   tmon_flags #(.NSRC(NSRC)) u_flags (
      .clk      (clk),
      .bat_rst_n(bat_rst_n),
      .src_i    (tamper_i),
      .en_i     (src_en),
      .clr_i    (wr_status ? wdata_i[NSRC-1:0] : '0),
      .flags_o  (flags),
      .event_o  (evt)
   );

   tmon_state u_state (
      .clk        (clk),
      .bat_rst_n  (bat_rst_n),
      .sys_rst_i  (sys_rst_i),
      .event_i    (evt),
      .clr_svf_i  (wr_status && wdata_i[SVF_BIT]),
      .clr_nvf_i  (wr_status && wdata_i[NVF_BIT]),
      .flags_any_i(|flags),
      .en_any_i   (|src_en),
      .fail_lock_i(ctrl.fail_lock),
      .svf_o      (svf),
      .nvf_o      (nvf)
   );

   tmon_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .bat_rst_n (bat_rst_n),
      .tick_i    (tick_i),
      .run_i     (ctrl.run),
      .frozen_i  (svf || nvf),
      .load_i    (wr_time),
      .load_val_i(wdata_i[CNT_W-1:0]),
      .count_o   (count)
   );

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge bat_rst_n) begin
         if (!bat_rst_n) irq_q <= 1'b0;
         else            irq_q <= svf && irq_en;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = svf && irq_en;
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         RA_STATUS: begin
            rdata_o[NSRC-1:0] = flags;
            rdata_o[SVF_BIT]  = svf;
            rdata_o[NVF_BIT]  = nvf;
         end
         RA_SRC_EN: rdata_o[NSRC-1:0] = src_en;
         RA_CTRL:   rdata_o[3:0]      = ctrl;
         RA_IRQ:    rdata_o[0]        = irq_en;
         RA_TIME:   rdata_o[CNT_W-1:0] = count;
         default:   rdata_o = '0;
      endcase
   end

   AST_EVENT_FAILS: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (|(tamper_i & src_en)) |=> svf);  // R2
   AST_IRQ_NEEDS_SVF: assert property (@(posedge clk) disable iff (!bat_rst_n)
      (IRQ_REGISTERED == 1'b0 && !svf) |-> !irq_o);  // R11
endmodule

// File: tb/tmon_supervisor_tb.sv
module tmon_supervisor_tb;
   localparam int NSRC = 10;
   localparam logic [2:0] A_ST = 3'd0, A_EN = 3'd1, A_CT = 3'd2, A_IQ = 3'd3, A_TM = 3'd4;
   localparam logic [31:0] SVF = 32'h1 << 16;
   localparam logic [31:0] NVF = 32'h1 << 17;

   logic clk = 1'b0;
   logic bat_rst_n = 1'b0;
   logic sys_rst_i = 1'b0;
   logic wr_en_i = 1'b0;
   logic [2:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic [NSRC-1:0] tamper_i = '0;
   logic tick_i = 1'b0;
   logic irq_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   tmon_supervisor u_dut (
      .clk(clk), .bat_rst_n(bat_rst_n), .sys_rst_i(sys_rst_i), .wr_en_i(wr_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .tamper_i(tamper_i),
      .tick_i(tick_i), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wdata_i = '0;
   endtask

   task automatic rdchk(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr_i = a;
      #1;
      chk(req, rdata_o, exp);
   endtask

   task automatic irqchk(input string req, input logic exp);
      @(negedge clk);
      chk(req, {31'b0, irq_o}, {31'b0, exp});
   endtask

   task automatic pulse(input logic [NSRC-1:0] m);
      @(negedge clk); tamper_i = m;
      @(negedge clk); tamper_i = '0;
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic sysrst();
      @(negedge clk); sys_rst_i = 1'b1;
      @(negedge clk); sys_rst_i = 1'b0;
   endtask

   task automatic batrst();
      @(negedge clk); bat_rst_n = 1'b0;
      @(negedge clk); bat_rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      bat_rst_n = 1'b1;

      // sweep every source, matching and mismatching enable
      for (int i = 0; i < NSRC; i++) begin
         for (int m = 0; m < 2; m++) begin
            logic [31:0] fbit;
            logic [31:0] en;
            fbit = 32'h1 << i;
            en   = (m == 1) ? fbit : (32'h1 << ((i + 1) % NSRC));
            batrst();
            rdchk("R1 status", A_ST, NVF);
            rdchk("R1 src_en", A_EN, 0);
            rdchk("R1 ctrl", A_CT, 0);
            rdchk("R1 time", A_TM, 0);
            irqchk("R1 irq", 1'b0);
            wr(A_ST, NVF);
            rdchk("R6 nvf clears when valid", A_ST, 0);
            wr(A_CT, 32'h8);
            wr(A_IQ, 32'h1);
            tick(3);
            rdchk("R3 counts", A_TM, 3);
            wr(A_EN, en);
            pulse(fbit[NSRC-1:0]);
            if (m == 0) begin
               rdchk("R2 disabled source ignored", A_ST, 0);
               irqchk("R11 irq low", 1'b0);
               tick(1);
               rdchk("R3 still counting", A_TM, 4);
            end else begin
               rdchk("R2 flag and svf", A_ST, fbit | SVF);
               irqchk("R11 irq high", 1'b1);
               tick(1);
               rdchk("R3 frozen", A_TM, 3);
               wr(A_TM, 32'd55);
               rdchk("R3 load ignored in failure", A_TM, 3);
               wr(A_ST, SVF);
               rdchk("R5 svf needs nvf", A_ST, fbit | SVF);
               sysrst();
               rdchk("R7 sysrst sets nvf", A_ST, fbit | SVF | NVF);
               irqchk("R7 R11 irq enable cleared", 1'b0);
               rdchk("R7 enables kept", A_EN, en);
               wr(A_ST, SVF);
               rdchk("R5 svf needs sources off", A_ST, fbit | SVF | NVF);
               wr(A_EN, 0);
               @(negedge clk); tamper_i = fbit[NSRC-1:0];
               wr(A_ST, fbit);
               @(negedge clk); tamper_i = '0;
               rdchk("R4 flag held while input high", A_ST, fbit | SVF | NVF);
               wr(A_ST, fbit | SVF);
               rdchk("R5 flag cleared, svf not in same write", A_ST, SVF | NVF);
               wr(A_ST, NVF);
               rdchk("R6 nvf held while svf", A_ST, SVF | NVF);
               wr(A_ST, SVF);
               rdchk("R5 svf clears in order", A_ST, NVF);
               wr(A_ST, NVF);
               rdchk("R6 nvf clears last", A_ST, 0);
               wr(A_TM, 32'd55);
               rdchk("R3 load when valid", A_TM, 55);
            end
         end
      end

      // locks
      batrst();
      wr(A_CT, 32'h8);
      tick(2);
      rdchk("R3 frozen while invalid", A_TM, 0);
      wr(A_TM, 32'd7);
      rdchk("R3 load while invalid only", A_TM, 7);
      wr(A_CT, 32'h1);
      wr(A_EN, 32'h3FF);
      rdchk("R8 soft lock blocks", A_EN, 0);
      wr(A_CT, 32'h0);
      rdchk("R9 soft lock not cleared by write", A_CT, 32'h1);
      sysrst();
      rdchk("R7 soft lock cleared", A_CT, 32'h0);
      wr(A_EN, 32'h155);
      rdchk("R8 write after soft unlock", A_EN, 32'h155);
      wr(A_CT, 32'h2);
      wr(A_EN, 32'h0);
      rdchk("R8 hard lock blocks", A_EN, 32'h155);
      sysrst();
      rdchk("R8 hard lock survives sysrst", A_CT, 32'h2);
      wr(A_EN, 32'h0);
      rdchk("R8 still blocked", A_EN, 32'h155);
      wr(A_CT, 32'h8);
      rdchk("R9 hard lock kept, run follows", A_CT, 32'hA);
      batrst();
      rdchk("R1 R8 battery reset clears locks", A_CT, 32'h0);

      // failure lock
      wr(A_CT, 32'h4);
      wr(A_EN, 32'h1);
      pulse(10'h1);
      sysrst();
      wr(A_EN, 32'h0);
      wr(A_ST, 32'h1);
      rdchk("R10 flag cleared", A_ST, SVF | NVF);
      wr(A_ST, SVF);
      rdchk("R10 svf stuck", A_ST, SVF | NVF);
      wr(A_CT, 32'h0);
      rdchk("R9 fail lock kept", A_CT, 32'h4);
      batrst();
      rdchk("R10 battery reset recovers", A_ST, NVF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule